// File: doc/BRIEF.md
# Time-Slice Destination Address Sequencer

This block chooses the IPv4 destination for outgoing readout data by absolute time, not per packet. Time is divided into slices of a programmable length in nanoseconds. Each slice is assigned to one entry of a table of server addresses, and the entries are used in rotation. Every node uses the same start instant and the same slice length, so every node sends a given slice to the same server.

Software configures the block while it is idle. It loads the address table, the number of active entries and the slice length. It then issues an arm command that carries an absolute start time. From that time on, the block announces each slice boundary with a one-cycle pulse, presents the slice index and the destination address for the new slice, and keeps a running flag high. The slice boundaries are tracked by adding the slice length to a stored boundary time, so no divider is needed. A stop input returns the block to idle.

Top module: `slice_dest_seq`

## Requirements
- R1: After reset, `dest_addr`, `slice_idx`, `slice_pulse`, `running` and `arm_err` are all zero. The entry count is 1, the slice length is 1000 ns, and all table entries are zero.
- R2: While idle, a `tbl_we` writes `tbl_data` into entry `tbl_idx`. A `cnt_we` with a value from 1 to DEPTH sets the entry count, and any other value is ignored. A `len_we` with a nonzero value sets the slice length, and zero is ignored.
- R3: An `arm` in idle with `start_ns >= now_ns` arms the block. On the first clock edge where `now_ns >= start_ns`, the first slice starts, and the outputs after that edge show `running`=1, `slice_pulse`=1, `slice_idx`=0 and `dest_addr` = entry 0.
- R4: While running, each later boundary at start + k·length gives a pulse. The slice index advances by one, and `dest_addr` takes the table entry of the new index. The boundary is taken on the first edge where `now_ns` has reached it. Each edge takes at most one boundary.
- R5: After index count−1, the next boundary wraps the index to 0. While running, the index always stays below the entry count.
- R6: `dest_addr` and `slice_idx` change while running only in a cycle in which `slice_pulse` is high. The pulse is one cycle per boundary.
- R7: An `arm` in idle with `start_ns < now_ns` sets `arm_err` and leaves the block idle. An accepted arm clears `arm_err`.
- R8: While the block is armed or running, writes to the table, the count and the length are ignored.
- R9: `stop` returns the block to idle on the next edge: `running`=0 and `slice_idx`=0. It has priority over everything else, and no pulse follows until the block is armed again.
- R10: An `arm` while armed or running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Table entry index to write |
| tbl_data | input | ADDR_W | Server address to store |
| cnt_we | input | 1 | Entry count write strobe |
| cnt_val | input | CNT_W | Number of entries in rotation |
| len_we | input | 1 | Slice length write strobe |
| len_val | input | LEN_W | Slice length in ns |
| arm | input | 1 | Start command strobe |
| start_ns | input | TIME_W | Absolute start time carried by `arm` |
| stop | input | 1 | Synchronous return to idle |
| now_ns | input | TIME_W | Absolute time in ns |
| dest_addr | output | ADDR_W | Destination address of current slice |
| slice_idx | output | IDX_W | Current slice index |
| slice_pulse | output | 1 | One-cycle boundary strobe |
| running | output | 1 | Sequencing active |
| arm_err | output | 1 | Last arm named a past start time |

## Verification
A directed pass arms the block with a start time slightly in the future and a fixed time step. This separates a first slice that starts too early or too late from one that starts on time. Changing the configuration, re-arming and stopping mid-run show whether locked state leaks into the next run, and an arm in the past separates the error path from a start. Random rounds then vary the count, including a single entry and a full table that wraps at every step. They also vary the slice length and use irregular time steps, including zero steps and jumps. These expose off-by-one errors in the wrap and in the boundary accumulation.

// File: rtl/slice_seq_pkg.sv
// Shared types for the time-slice destination sequencer.
package slice_seq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_RUN   = 2'd2
    } sq_state_e;
endpackage

// File: rtl/slice_addr_table.sv
// Register file of server addresses. It is written during configuration and read
// combinationally by slice index. Assumes lock is high whenever writes must be refused.
module slice_addr_table #(
    parameter int DEPTH = 64,
    parameter int AW    = 32,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          lock,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);
    logic [AW-1:0] mem [DEPTH];

    // Store an entry when unlocked. Clear all entries on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && !lock && (int'(wr_idx) < DEPTH)) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Combinational read port.
    always_comb rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
endmodule

// File: rtl/slice_boundary_track.sv
// Holds the absolute time of the next slice boundary. It is loaded with the start
// time and moved forward by the slice length after each boundary is taken.
// Assumes now_ns is monotonic.
module slice_boundary_track #(
    parameter int TW = 64,
    parameter int LW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_time,
    input  logic          advance,
    input  logic [LW-1:0] len,
    input  logic [TW-1:0] now_ns,
    output logic          reach
);
    logic [TW-1:0] nxt_q;

    // Next-boundary accumulator: load on arm, add the length after each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       nxt_q <= '0;
        else if (load)    nxt_q <= load_time;
        else if (advance) nxt_q <= nxt_q + TW'(len);
    end

    // The boundary is due once the time base has reached it.
    always_comb reach = (now_ns >= nxt_q);
endmodule

// File: rtl/slice_index_ctr.sv
// Slice index counter that wraps after count-1. Assumes count is in 1..DEPTH
// and does not change while step can be asserted.
module slice_index_ctr #(
    parameter int IW = 6,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] count,
    output logic [IW-1:0] idx,
    output logic [IW-1:0] idx_next
);
    // Successor index with wrap at the last active entry.
    always_comb begin
        if (CW'(idx) == (count - CW'(1))) idx_next = '0;
        else                              idx_next = idx + IW'(1);
    end

    // Index register: clear wins over step.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx <= '0;
        else if (clear) idx <= '0;
        else if (step)  idx <= idx_next;
    end
endmodule

// File: rtl/slice_dest_seq.sv
// Top of the time-slice destination sequencer. Idle: accepts configuration and
// arm. Armed: waits for the start time. Run: rotates through the table, one entry
// per slice. Assumes now_ns is an absolute ns count that does not decrease.
module slice_dest_seq
    import slice_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DEPTH   = 64,
    parameter int TIME_W  = 64,
    parameter int LEN_W   = 32,
    parameter int DEF_LEN = 1000,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_data,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              arm,
    input  logic [TIME_W-1:0] start_ns,
    input  logic              stop,
    input  logic [TIME_W-1:0] now_ns,
    output logic [ADDR_W-1:0] dest_addr,
    output logic [IDX_W-1:0]  slice_idx,
    output logic              slice_pulse,
    output logic              running,
    output logic              arm_err
);
    sq_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] dest_q;
    logic              pulse_q;
    logic              err_q;
    logic              idle, reach, accept, take;
    logic [IDX_W-1:0]  idx_cur, idx_nxt, rd_idx;
    logic [ADDR_W-1:0] rd_data;

    // Decode of the control events for this cycle.
    always_comb begin
        idle   = (state_q == SQ_IDLE);
        accept = idle && arm && !stop && (start_ns >= now_ns);
        take   = !stop && !idle && reach;
        rd_idx = (state_q == SQ_RUN) ? idx_nxt : '0;
    end

    slice_addr_table #(.DEPTH(DEPTH), .AW(ADDR_W), .IW(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .lock(!idle),
        .wr_idx(tbl_idx), .wr_data(tbl_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    slice_boundary_track #(.TW(TIME_W), .LW(LEN_W)) u_bound (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_time(start_ns),
        .advance(take), .len(len_q), .now_ns(now_ns), .reach(reach)
    );

    slice_index_ctr #(.IW(IDX_W), .CW(CNT_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .clear(stop || accept),
        .step(take && (state_q == SQ_RUN)), .count(cnt_q),
        .idx(idx_cur), .idx_next(idx_nxt)
    );

    // Configuration registers, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(1);
            len_q <= LEN_W'(DEF_LEN);
        end else if (idle) begin
            if (cnt_we && (cnt_val != '0) && (cnt_val <= CNT_W'(DEPTH))) cnt_q <= cnt_val;
            if (len_we && (len_val != '0)) len_q <= len_val;
        end
    end

    // Sequencer state, boundary strobe, destination and arm error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            dest_q  <= '0;
            pulse_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (stop) begin
                state_q <= SQ_IDLE;
            end else begin
                case (state_q)
                    SQ_IDLE: if (arm) begin
                        if (accept) begin
                            state_q <= SQ_ARMED;
                            err_q   <= 1'b0;
                        end else begin
                            err_q   <= 1'b1;
                        end
                    end
                    SQ_ARMED, SQ_RUN: if (reach) begin
                        state_q <= SQ_RUN;
                        pulse_q <= 1'b1;
                        dest_q  <= rd_data;
                    end
                    default: state_q <= SQ_IDLE;
                endcase
            end
        end
    end

    // Output mapping.
    always_comb begin
        dest_addr   = dest_q;
        slice_idx   = idx_cur;
        slice_pulse = pulse_q;
        running     = (state_q == SQ_RUN);
        arm_err     = err_q;
    end
endmodule

// File: rtl/slice_dest_seq_chk.sv
// Assertion checker for slice_dest_seq, attached by bind below.
module slice_dest_seq_chk #(
    parameter int AW = 32,
    parameter int IW = 6,
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop,
    input logic          slice_pulse,
    input logic          running,
    input logic          arm_err,
    input logic [IW-1:0] slice_idx,
    input logic [AW-1:0] dest_addr,
    input logic [CW-1:0] cnt_q
);
    AST_PULSE_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        slice_pulse |-> running); // R3
    AST_DEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_pulse |-> $stable(dest_addr)); // R6
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!slice_pulse && running) |-> $stable(slice_idx)); // R6
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (CW'(slice_idx) < cnt_q)); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_pulse && $past(running) && (CW'($past(slice_idx)) == cnt_q - CW'(1)))
        |-> (slice_idx == '0)); // R5
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!running && slice_idx == '0)); // R9
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        arm_err |-> !running); // R7
endmodule

bind slice_dest_seq slice_dest_seq_chk #(.AW(ADDR_W), .IW(IDX_W), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop(stop), .slice_pulse(slice_pulse),
    .running(running), .arm_err(arm_err), .slice_idx(slice_idx),
    .dest_addr(dest_addr), .cnt_q(cnt_q)
);

// File: tb/slice_dest_seq_tb_top.sv
// Self-checking bench: a reference model built from the requirements is stepped
// each cycle. The stimulus is directed at first, then randomized with a fixed seed.
module slice_dest_seq_tb_top;
    localparam int DEPTH = 64;
    localparam int IW = 6;
    localparam int CW = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0, cnt_we = 1'b0, len_we = 1'b0, arm = 1'b0, stop = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [31:0] tbl_data = '0;
    logic [CW-1:0] cnt_val = '0;
    logic [31:0] len_val = '0;
    logic [63:0] start_ns = '0;
    logic [63:0] now_ns = 64'd1_000_000_000;
    logic [31:0] dest_addr;
    logic [IW-1:0] slice_idx;
    logic        slice_pulse, running, arm_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int now_step = 8;

    // Reference model state.
    logic [31:0] m_tbl [DEPTH];
    int          m_cnt, m_idx, m_state;
    logic [31:0] m_len, m_dest;
    logic [63:0] m_nxt;
    bit          m_pulse, m_err;

    always #5 clk = ~clk;

    slice_dest_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .cnt_we(cnt_we), .cnt_val(cnt_val), .len_we(len_we), .len_val(len_val),
        .arm(arm), .start_ns(start_ns), .stop(stop), .now_ns(now_ns),
        .dest_addr(dest_addr), .slice_idx(slice_idx), .slice_pulse(slice_pulse),
        .running(running), .arm_err(arm_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model update for one clock edge, using the inputs applied before it (0 idle, 1 armed, 2 run).
    task automatic model_edge();
        m_pulse = 0;
        if (m_state == 0) begin
            if (tbl_we) m_tbl[tbl_idx] = tbl_data;
            if (cnt_we && cnt_val >= 1 && int'(cnt_val) <= DEPTH) m_cnt = int'(cnt_val);
            if (len_we && len_val != 0) m_len = len_val;
        end
        if (stop) begin
            m_state = 0; m_idx = 0;
        end else if (m_state == 0) begin
            if (arm) begin
                if (start_ns < now_ns) m_err = 1;
                else begin m_err = 0; m_state = 1; m_nxt = start_ns; end
            end
        end else if (now_ns >= m_nxt) begin
            if (m_state == 1) m_idx = 0;
            else m_idx = (m_idx == m_cnt - 1) ? 0 : m_idx + 1;
            m_state = 2; m_pulse = 1; m_dest = m_tbl[m_idx];
            m_nxt = m_nxt + 64'(m_len);
        end
    endtask

    // One cycle: update the model, clock the design, compare at the negedge, then release strobes and advance time.
    task automatic cycle();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk(slice_pulse == m_pulse, "R6 pulse", 64'(slice_pulse), 64'(m_pulse));
        chk(dest_addr == m_dest, "R4 dest_addr", 64'(dest_addr), 64'(m_dest));
        chk(int'(slice_idx) == m_idx, "R5 slice_idx", 64'(slice_idx), 64'(m_idx));
        chk(running == (m_state == 2), "R3 running", 64'(running), 64'(m_state == 2));
        chk(arm_err == m_err, "R7 arm_err", 64'(arm_err), 64'(m_err));
        tbl_we = 0; cnt_we = 0; len_we = 0; arm = 0; stop = 0;
        now_ns = now_ns + 64'(now_step);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr_tbl(input int i, input logic [31:0] d);
        tbl_we = 1; tbl_idx = IW'(i); tbl_data = d; cycle();
    endtask

    task automatic wr_cnt(input int c);
        cnt_we = 1; cnt_val = CW'(c); cycle();
    endtask

    task automatic wr_len(input logic [31:0] l);
        len_we = 1; len_val = l; cycle();
    endtask

    task automatic do_arm(input logic [63:0] t);
        arm = 1; start_ns = t; cycle();
    endtask

    task automatic do_stop();
        stop = 1; cycle();
    endtask

    // Main stimulus.
    initial begin
        int pulses;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) m_tbl[i] = '0;
        m_cnt = 1; m_len = 1000; m_dest = 0; m_idx = 0; m_state = 0;
        m_nxt = 0; m_pulse = 0; m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(dest_addr == 0 && slice_idx == 0 && !slice_pulse && !running && !arm_err,
            "R1 reset outputs", {dest_addr, 25'(slice_idx), slice_pulse, running, arm_err}, 64'd0);

        // R2: configuration, with illegal count and length values ignored
        wr_tbl(0, 32'hC0A8_0001); wr_tbl(1, 32'hC0A8_0002);
        wr_tbl(2, 32'hC0A8_0003); wr_tbl(3, 32'hC0A8_0004);
        wr_cnt(4); wr_cnt(0); wr_cnt(65); wr_len(100); wr_len(0);

        // R3, R4, R5: first slice at start time, then rotation
        do_arm(now_ns + 64'd50);
        pulses = 0;
        for (int i = 0; i < 70; i++) begin cycle(); if (slice_pulse) pulses++; end
        chk(pulses >= 5, "R5 rotation pulses seen", 64'(pulses), 64'd5);

        // R8, R10: writes and re-arm while running are ignored
        wr_tbl(0, 32'hDEAD_BEEF); wr_cnt(2); wr_len(16);
        do_arm(now_ns + 64'd1000);
        run(30);

        // R9: stop, then no pulses while idle
        do_stop();
        chk(!running && slice_idx == 0, "R9 idle after stop", 64'(running), 64'd0);
        pulses = 0;
        for (int i = 0; i < 20; i++) begin cycle(); if (slice_pulse) pulses++; end
        chk(pulses == 0, "R9 no pulse after stop", 64'(pulses), 64'd0);

        // R7: arm in the past raises the error and does not start
        do_arm(now_ns - 64'd1);
        run(10);
        chk(arm_err && !running, "R7 past start rejected", 64'(arm_err), 64'd1);

        // R8: first slice after re-arm uses the value stored before the locked write
        do_arm(now_ns + 64'd16);
        while (!slice_pulse) cycle();
        chk(dest_addr == 32'hC0A8_0001, "R8 locked write ignored", 64'(dest_addr), 64'hC0A8_0001);
        chk(!arm_err, "R7 error cleared by accepted arm", 64'(arm_err), 64'd0);
        run(20);

        // Random rounds: count 1, full-table wrap every step, then random sizes
        for (int r = 0; r < 6; r++) begin
            int c;
            logic [31:0] l;
            do_stop();
            now_step = 8;
            c = (r == 0) ? 1 : (r == 1) ? DEPTH : 1 + int'($urandom % 8);
            l = (r == 1) ? 32'd8 : 32'd8 + ($urandom % 120);
            for (int i = 0; i < c; i++) wr_tbl(i, $urandom);
            wr_cnt(c); wr_len(l);
            do_arm(now_ns + 64'($urandom % 200));
            for (int i = 0; i < 140; i++) begin
                if (r != 1) now_step = int'($urandom % 25);
                cycle();
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule